// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a processor core that completes one instruction per clock cycle. It covers a small integer subset of a classic 32-bit load/store instruction set: register-register add, subtract, AND, OR and set-less-than, plus load word, store word, branch-if-equal, add-immediate and an absolute jump. Inside the core are the program counter, the next-address selection, a 32-entry register file, immediate sign extension, the ALU and a two-level decoder. The opcode first picks an ALU operation class. Only the register-register class then looks at the function field to choose the ALU control.

Instruction memory and data memory both sit outside the core. The core presents the current program counter as the fetch address and takes the instruction word back in the same cycle. Data accesses work the same way: the core drives an address, write data and a write strobe, and reads the load data combinationally. Stores take effect at the next rising clock edge.

Top module: `sc_core`

## Requirements
- R1: While the synchronous active-high reset is sampled high at a rising edge, the program counter (the fetch address `imem_addr`) becomes 0.
- R2: Instructions that do not redirect control flow advance the fetch address by 4 on every rising edge.
- R3: Opcode 000000 (bits 31:26) is register-register. It writes register rd (bits 15:11) with rs (25:21) op rt (20:16), where funct (bits 5:0) 100000 = add, 100010 = subtract, 100100 = AND, 100101 = OR.
- R4: Funct 101010 (set-less-than) writes 1 to rd when the sign bit of rs minus rt is 1, and writes 0 otherwise.
- R5: Opcode 100011 loads register rt from data address rs + sign-extended imm16 (bits 15:0). Opcode 101011 stores rt to that address. Negative offsets must work.
- R6: Opcode 001000 writes rs + sign-extended imm16 to register rt.
- R7: Opcode 000100 branches when rs equals rt, to PC+4 + (sign-extended imm16 shifted left by 2). Otherwise it falls through to PC+4. Backward offsets must work.
- R8: Opcode 000010 jumps to {PC+4[31:28], bits 25:0 of the instruction, 2'b00}.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: Any other opcode is a no-op: no register write, no data write, and the PC advances by 4. The same applies to register-register words with any other funct or with a nonzero bits 10:6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Fetch address (program counter) |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data byte address (ALU result) |
| dmem_wdata | output | 32 | Store data (register rt) |
| dmem_we | output | 1 | Store strobe, write at next rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr` |

## Verification
The bench runs a short program for each scenario and observes results only through stores into its data-memory model and through the final fetch address. It targets these corner cases:
- A negative immediate. A design that zero-extends the immediate would compute a wrong sum and store to or load from the wrong word.
- A taken forward branch, a not-taken branch and a backward self-branch. An unshifted or wrongly based target would skip the wrong instruction or halt at the wrong address.
- A jump over two instructions. A bad target here leaves a wrong value in the stored register.
- Writes aimed at register 0 must vanish.
- Unknown opcodes, unknown funct values and nonzero shift fields must leave registers and memory untouched. The bench counts every store strobe to catch a decoder that lets one of these through.

// File: rtl/sc_core.sv
module sc_core #(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);
  localparam logic [5:0] OP_RR   = 6'b000000;
  localparam logic [5:0] OP_LOAD = 6'b100011;
  localparam logic [5:0] OP_STOR = 6'b101011;
  localparam logic [5:0] OP_BEQ  = 6'b000100;
  localparam logic [5:0] OP_ADDI = 6'b001000;
  localparam logic [5:0] OP_JMP  = 6'b000010;

  localparam logic [1:0] CLS_ADD = 2'b00;
  localparam logic [1:0] CLS_SUB = 2'b01;
  localparam logic [1:0] CLS_FN  = 2'b10;

  logic [31:0] pc, pc_plus4, imm_ext, rd1, rd2, alu_b, b_eff, sum, alu_res;
  logic [31:0] wb_data, br_target, jmp_target;
  logic [5:0]  op, funct;
  logic [4:0]  rs, rt, rd, wa;
  logic        reg_write, reg_dst, alu_src, branch, mem_write, mem_to_reg, jump;
  logic        rr_ok, known_op, zero, take_branch;
  logic [1:0]  alu_cls;
  logic [2:0]  alu_ctl;
  logic [31:0] rf [32];

  assign op    = imem_rdata[31:26];
  assign rs    = imem_rdata[25:21];
  assign rt    = imem_rdata[20:16];
  assign rd    = imem_rdata[15:11];
  assign funct = imem_rdata[5:0];

  assign rr_ok = (imem_rdata[10:6] == 5'd0) &&
                 (funct inside {6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010});

  always_comb begin
    {reg_write, reg_dst, alu_src, branch, mem_write, mem_to_reg, jump} = '0;
    alu_cls  = CLS_ADD;
    known_op = 1'b1;
    case (op)
      OP_RR:   begin reg_write = rr_ok; reg_dst = 1'b1; alu_cls = CLS_FN; known_op = rr_ok; end
      OP_LOAD: begin reg_write = 1'b1; alu_src = 1'b1; mem_to_reg = 1'b1; end
      OP_STOR: begin alu_src = 1'b1; mem_write = 1'b1; end
      OP_BEQ:  begin branch = 1'b1; alu_cls = CLS_SUB; end
      OP_ADDI: begin reg_write = 1'b1; alu_src = 1'b1; end
      OP_JMP:  jump = 1'b1;
      default: known_op = 1'b0;
    endcase
  end

  always_comb begin
    case (alu_cls)
      CLS_ADD: alu_ctl = 3'b010;
      CLS_SUB: alu_ctl = 3'b110;
      default:
        case (funct)
          6'b100010: alu_ctl = 3'b110;
          6'b100100: alu_ctl = 3'b000;
          6'b100101: alu_ctl = 3'b001;
          6'b101010: alu_ctl = 3'b111;
          default:   alu_ctl = 3'b010;
        endcase
    endcase
  end

  assign imm_ext = {{16{imem_rdata[15]}}, imem_rdata[15:0]};
  assign rd1     = (rs == 5'd0) ? 32'd0 : rf[rs];
  assign rd2     = (rt == 5'd0) ? 32'd0 : rf[rt];
  assign alu_b   = alu_src ? imm_ext : rd2;
  assign b_eff   = alu_ctl[2] ? ~alu_b : alu_b;
  assign sum     = rd1 + b_eff + {31'd0, alu_ctl[2]};

  always_comb begin
    case (alu_ctl[1:0])
      2'b00:   alu_res = rd1 & b_eff;
      2'b01:   alu_res = rd1 | b_eff;
      2'b10:   alu_res = sum;
      default: alu_res = {31'd0, sum[31]};
    endcase
  end

  assign zero        = (alu_res == 32'd0);
  assign take_branch = branch & zero;
  assign pc_plus4    = pc + 32'd4;
  assign br_target   = pc_plus4 + {imm_ext[29:0], 2'b00};
  assign jmp_target  = {pc_plus4[31:28], imem_rdata[25:0], 2'b00};
  assign wa          = reg_dst ? rd : rt;
  assign wb_data     = mem_to_reg ? dmem_rdata : alu_res;

  always_ff @(posedge clk) begin
    if (rst)              pc <= RESET_PC;
    else if (jump)        pc <= jmp_target;
    else if (take_branch) pc <= br_target;
    else                  pc <= pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (reg_write && wa != 5'd0) rf[wa] <= wb_data;
  end

  assign imem_addr  = pc;
  assign dmem_addr  = alu_res;
  assign dmem_wdata = rd2;
  assign dmem_we    = mem_write;

  a_r1_reset_pc: assert property (@(posedge clk) rst |=> (imem_addr == RESET_PC));

  a_r2_seq_pc: assert property (@(posedge clk) disable iff (rst)
    (!branch && !jump) |=> (imem_addr == $past(imem_addr) + 32'd4));

  a_r7_beq_unequal: assert property (@(posedge clk) disable iff (rst)
    (branch && rd1 != rd2) |=> (imem_addr == $past(imem_addr) + 32'd4));

  a_r8_jump_target: assert property (@(posedge clk) disable iff (rst)
    jump |=> (imem_addr == {$past(pc_plus4[31:28]), $past(imem_rdata[25:0]), 2'b00}));

  a_r9_store_r0: assert property (@(posedge clk) disable iff (rst)
    (dmem_we && rt == 5'd0) |-> (dmem_wdata == 32'd0));

  a_r10_unknown_quiet: assert property (@(posedge clk) disable iff (rst)
    !known_op |-> (!dmem_we && !reg_write));
endmodule

// File: tb/sc_core_tb.sv
module sc_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  int          wr_cnt = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  sc_core u_dut (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) dmem[i] <= 32'hA5A5A5A5;
      wr_cnt <= 0;
    end else if (dmem_we) begin
      dmem[dmem_addr[7:2]] <= dmem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  function automatic logic [31:0] rr(input int s, input int t, input int d, input logic [5:0] fn);
    return {6'b000000, 5'(s), 5'(t), 5'(d), 5'd0, fn};
  endfunction
  function automatic logic [31:0] it(input logic [5:0] o, input int s, input int t, input int imm);
    return {o, 5'(s), 5'(t), 16'(imm)};
  endfunction
  function automatic logic [31:0] jw(input int idx);
    return {6'b000010, 26'(idx)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) imem[i] = 32'd0;
  endtask

  task automatic run(input int cycles);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic t_reset_seq();
    clear_prog();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 reset pc", imem_addr, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 pc+4 first", imem_addr, 32'd4);
    repeat (3) @(negedge clk);
    check("R2 pc+4 run", imem_addr, 32'd16);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-run", imem_addr, 32'd0);
  endtask

  task automatic t_alu();
    clear_prog();
    imem[0]  = it(6'b001000, 0, 1, 5);
    imem[1]  = it(6'b001000, 0, 2, -3);
    imem[2]  = rr(1, 2, 3, 6'b100000);
    imem[3]  = rr(1, 2, 4, 6'b100010);
    imem[4]  = rr(1, 2, 5, 6'b100100);
    imem[5]  = rr(1, 2, 6, 6'b100101);
    imem[6]  = rr(2, 1, 7, 6'b101010);
    imem[7]  = rr(1, 2, 8, 6'b101010);
    for (int k = 0; k < 6; k++) imem[8 + k] = it(6'b101011, 0, 3 + k, 4 * k);
    imem[14] = jw(14);
    run(25);
    check("R3 add", dmem[0], 32'd2);
    check("R3 sub", dmem[1], 32'd8);
    check("R3 and", dmem[2], 32'd5);
    check("R3 or / R6 negative imm", dmem[3], 32'hFFFFFFFD);
    check("R4 slt true", dmem[4], 32'd1);
    check("R4 slt false", dmem[5], 32'd0);
    check("R8 halt address", imem_addr, 32'd56);
  endtask

  task automatic t_mem();
    clear_prog();
    imem[0] = it(6'b001000, 0, 1, 40);
    imem[1] = it(6'b001000, 0, 2, 32'h1234);
    imem[2] = it(6'b101011, 1, 2, -8);
    imem[3] = it(6'b100011, 1, 3, -8);
    imem[4] = it(6'b001000, 3, 3, 1);
    imem[5] = it(6'b101011, 1, 3, 4);
    imem[6] = jw(6);
    run(15);
    check("R5 store negative offset", dmem[8], 32'h1234);
    check("R5 load then addi R6", dmem[11], 32'h1235);
    check("R5 store count", 32'(wr_cnt), 32'd2);
  endtask

  task automatic t_branch();
    clear_prog();
    imem[0] = it(6'b001000, 0, 3, 0);
    imem[1] = it(6'b001000, 0, 1, 7);
    imem[2] = it(6'b001000, 0, 2, 7);
    imem[3] = it(6'b000100, 1, 2, 1);
    imem[4] = it(6'b001000, 0, 3, 99);
    imem[5] = it(6'b000100, 1, 0, 1);
    imem[6] = it(6'b001000, 0, 4, 55);
    imem[7] = it(6'b101011, 0, 3, 0);
    imem[8] = it(6'b101011, 0, 4, 4);
    imem[9] = it(6'b000100, 0, 0, -1);
    run(20);
    check("R7 taken skips", dmem[0], 32'd0);
    check("R7 not taken falls through", dmem[1], 32'd55);
    check("R7 backward self branch", imem_addr, 32'd36);
  endtask

  task automatic t_jump();
    clear_prog();
    imem[0] = it(6'b001000, 0, 1, 1);
    imem[1] = jw(4);
    imem[2] = it(6'b001000, 0, 1, 2);
    imem[3] = it(6'b001000, 0, 1, 3);
    imem[4] = it(6'b101011, 0, 1, 0);
    imem[5] = jw(5);
    run(12);
    check("R8 jump skips", dmem[0], 32'd1);
    check("R8 jump to self", imem_addr, 32'd20);
  endtask

  task automatic t_zero_reg();
    clear_prog();
    imem[0] = it(6'b001000, 0, 1, 6);
    imem[1] = it(6'b001000, 0, 0, 77);
    imem[2] = rr(1, 1, 0, 6'b100000);
    imem[3] = it(6'b101011, 0, 0, 0);
    imem[4] = rr(0, 1, 2, 6'b100000);
    imem[5] = it(6'b101011, 0, 2, 4);
    imem[6] = jw(6);
    run(14);
    check("R9 r0 stays zero", dmem[0], 32'd0);
    check("R9 r0 reads zero", dmem[1], 32'd6);
  endtask

  task automatic t_nop();
    clear_prog();
    imem[0] = it(6'b001000, 0, 1, 9);
    imem[1] = it(6'b111111, 0, 1, 32'h44);
    imem[2] = rr(0, 0, 1, 6'b000111);
    imem[3] = {6'b000000, 5'd0, 5'd0, 5'd1, 5'd3, 6'b100000};
    imem[4] = it(6'b101000, 0, 1, 8);
    imem[5] = it(6'b101011, 0, 1, 0);
    imem[6] = jw(6);
    run(14);
    check("R10 register untouched", dmem[0], 32'd9);
    check("R10 no extra store", 32'(wr_cnt), 32'd1);
    check("R10 unknown store word intact", dmem[2], 32'hA5A5A5A5);
    check("R10 pc advanced", imem_addr, 32'd24);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    clear_prog();
    t_reset_seq();
    t_alu();
    t_mem();
    t_branch();
    t_jump();
    t_zero_reg();
    t_nop();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule